// File: doc/BRIEF.md
# Power-Good and Latched Fault Supervisor

This block supervises the output of a switching regulator controller from synchronous comparator flags. It decides when the power-good indication may be raised, and it latches the controller off when the output goes out of range. A high excursion latches an over-voltage fault, which holds the low-side switch on to drain the output. A low excursion latches an under-voltage fault, which puts the output stage into high impedance. Each of these decisions takes effect only after its condition has persisted for a deglitch window of `DEGLITCH_CYCLES` clocks. The default of 1250 clocks is 5 µs at 250 MHz.

The regulator runs only while the supply-good input and the enable input are both high. Dropping either one clears any latched fault and restarts the supervision, so a fault is cleared by toggling one of those inputs. An over-temperature flag suspends PWM for as long as it is high. It does not latch anything and does not affect power-good. Under-voltage detection is masked until soft start reports completion, so the start-up ramp is never flagged as a fault.

Top module: `pgood_supervisor`

## Requirements
- R1: When the over-range flag or the under-range flag stays high for DEGLITCH_CYCLES consecutive clocks, power-good falls on that clock edge. It stays low while the flag remains high.
- R2: Power-good rises only after soft-done, at-90% high, and both range flags low have held together for DEGLITCH_CYCLES consecutive clocks. While soft-done or at-90% is low, power-good stays low.
- R3: A condition that lasts fewer than DEGLITCH_CYCLES consecutive clocks changes no output. Any break in the condition restarts the count.
- R4: When the over-range flag stays high for DEGLITCH_CYCLES clocks, ov_fault and lowside_on assert one clock later. They stay high after the flag clears, until the block is cleared.
- R5: When the under-range flag stays high for DEGLITCH_CYCLES clocks while soft-done is high, uv_fault and hiz_out assert one clock later and stay latched. While soft-done is low, the under-range flag is ignored.
- R6: If both range conditions qualify on the same clock, only ov_fault latches. At most one fault is ever latched, and no second fault latches while one is held.
- R7: Driving supply_ok or enable low clears both faults on the next clock edge and forces power-good low. The same holds after reset. A fault is never cleared in any other way.
- R8: The over-temperature flag raises pwm_suspend one clock later, while the block runs, and it latches nothing and leaves power-good unchanged. pwm_suspend is also high whenever a fault is latched.
- R9: Power-good is low whenever a fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | Supply above lockout threshold |
| enable | input | 1 | Regulator enable |
| soft_done | input | 1 | Soft-start sequence complete |
| over_flag | input | 1 | Output more than 20% above setpoint |
| under_flag | input | 1 | Output more than 10% below setpoint |
| at90_flag | input | 1 | Output at or above 90% of setpoint |
| hot_flag | input | 1 | Over-temperature detected |
| pgood | output | 1 | Power-good indication |
| ov_fault | output | 1 | Latched over-voltage fault |
| uv_fault | output | 1 | Latched under-voltage fault |
| lowside_on | output | 1 | Command holding the low-side switch on |
| hiz_out | output | 1 | Command placing the output stage in high impedance |
| pwm_suspend | output | 1 | Command pausing PWM switching |

## Verification
The hardest case to reach is a window count that restarts. The over-range flag is held for one clock short of the window, dropped for a single clock, then held short again. The test shows that neither the fault latch nor power-good moves, even though the flag was high for far more than the window in total.

The priority case is also delicate. Both range flags are raised on the same clock with soft start done, so both filters expire on the same edge. Masked under-voltage is reached by deasserting soft-done while the under-range flag is held well past the window. Each of these tests is followed by a clear through supply_ok or enable, which shows at the outputs that the latches really did hold and then really did release.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Indices of the persistence filters inside the supervisor.
  localparam int unsigned FLT_OV    = 0;
  localparam int unsigned FLT_UV    = 1;
  localparam int unsigned FLT_GOOD  = 2;
  localparam int unsigned FLT_COUNT = 3;

  typedef struct packed {
    logic ov;
    logic uv;
  } fault_t;
endpackage

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int unsigned N = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic q
);
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_q, q_d;

  always_comb begin
    q_d   = q_q;
    cnt_d = cnt_q;
    if (clr) begin
      q_d   = 1'b0;
      cnt_d = '0;
    end else if (din == q_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      q_d   = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      q_q   <= q_d;
      cnt_q <= cnt_d;
    end
  end

  assign q = q_q;

  // R3: the output only moves after a full window of disagreement, or on clear
  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_q != $past(q_q)) |-> ($past(clr) || ($past(cnt_q) == LAST && $past(din) == q_q)));
endmodule

// File: rtl/fault_latch.sv
module fault_latch
  import sup_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   ov_qual,
  input  logic   uv_qual,
  output fault_t fault
);
  fault_t f_q, f_d;

  always_comb begin
    f_d = f_q;
    if (clr) begin
      f_d = '0;
    end else if (!f_q.ov && !f_q.uv) begin
      if (ov_qual)      f_d.ov = 1'b1;   // over-voltage wins a tie
      else if (uv_qual) f_d.uv = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_d;
  end

  assign fault = f_q;

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({f_q.ov, f_q.uv}));
  assert_ov_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q.ov && !clr) |=> f_q.ov);
  assert_uv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q.uv && !clr) |=> f_q.uv);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!f_q.ov && !f_q.uv));
  assert_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !f_q.ov && !f_q.uv && ov_qual) |=> (f_q.ov && !f_q.uv));
endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned DEGLITCH_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic enable,
  input  logic soft_done,
  input  logic over_flag,
  input  logic under_flag,
  input  logic at90_flag,
  input  logic hot_flag,
  output logic pgood,
  output logic ov_fault,
  output logic uv_fault,
  output logic lowside_on,
  output logic hiz_out,
  output logic pwm_suspend
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic run, clr;
  assign run = supply_ok & enable;
  assign clr = ~run;

  logic [FLT_COUNT-1:0] flt_in, flt_q;
  assign flt_in[FLT_OV]   = over_flag;
  assign flt_in[FLT_UV]   = under_flag & soft_done;
  assign flt_in[FLT_GOOD] = soft_done & at90_flag & ~over_flag & ~under_flag;

  for (genvar i = 0; i < FLT_COUNT; i++) begin : g_flt
    persist_filter #(.N(DEGLITCH_CYCLES)) u_flt (
      .clk  (clk),
      .rst_n(rst_n_s),
      .clr  (clr),
      .din  (flt_in[i]),
      .q    (flt_q[i])
    );
  end

  fault_t fault;

  fault_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (clr),
    .ov_qual(flt_q[FLT_OV]),
    .uv_qual(flt_q[FLT_UV]),
    .fault  (fault)
  );

  // Over-temperature pause: registered, enabled only while running.
  logic hot_q, hot_d;
  always_comb begin
    hot_d = 1'b0;
    if (run) hot_d = hot_flag;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) hot_q <= 1'b0;
    else          hot_q <= hot_d;
  end

  logic any_fault;
  assign any_fault   = fault.ov | fault.uv;
  assign pgood       = flt_q[FLT_GOOD] & ~any_fault;
  assign ov_fault    = fault.ov;
  assign uv_fault    = fault.uv;
  assign lowside_on  = fault.ov;
  assign hiz_out     = fault.uv;
  assign pwm_suspend = hot_q | any_fault;

  assert_fault_kills_pgood_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ov_fault || uv_fault) |-> !pgood);
  assert_pgood_needs_soft_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(pgood) |-> ($past(soft_done) && $past(at90_flag)));
  assert_hot_suspends_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run && hot_flag) |=> pwm_suspend);
  assert_stop_drops_pgood_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !run |=> !pgood);
endmodule

// File: tb/tb_pgood_supervisor.sv
module tb_pgood_supervisor;
  localparam int DG = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, enable, soft_done, over_flag, under_flag, at90_flag, hot_flag;
  logic pgood, ov_fault, uv_fault, lowside_on, hiz_out, pwm_suspend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pgood_supervisor #(.DEGLITCH_CYCLES(DG)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
    .soft_done(soft_done), .over_flag(over_flag), .under_flag(under_flag),
    .at90_flag(at90_flag), .hot_flag(hot_flag), .pgood(pgood),
    .ov_fault(ov_fault), .uv_fault(uv_fault), .lowside_on(lowside_on),
    .hiz_out(hiz_out), .pwm_suspend(pwm_suspend)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic restart();
    supply_ok = 1'b0;
    cyc(1);
    supply_ok = 1'b1;
    cyc(DG);
    check("R7", "pgood back after clear", pgood, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; supply_ok = 1'b0; enable = 1'b0; soft_done = 1'b0;
    over_flag = 1'b0; under_flag = 1'b0; at90_flag = 1'b0; hot_flag = 1'b0;
    cyc(3);
    check("R7", "reset pgood", pgood, 1'b0);
    check("R7", "reset faults", ov_fault | uv_fault, 1'b0);
    check("R7", "reset drive cmds", lowside_on | hiz_out | pwm_suspend, 1'b0);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_startup();
    supply_ok = 1'b1; enable = 1'b1; at90_flag = 1'b1; soft_done = 1'b0;
    cyc(3 * DG);
    check("R2", "held low before soft done", pgood, 1'b0);
    soft_done = 1'b1;
    cyc(DG - 1);
    check("R2", "one short of window", pgood, 1'b0);
    cyc(1);
    check("R2", "pgood after window", pgood, 1'b1);
  endtask

  task automatic t_glitch();
    over_flag = 1'b1; cyc(DG - 1);
    over_flag = 1'b0; cyc(1);
    over_flag = 1'b1; cyc(DG - 1);
    over_flag = 1'b0; cyc(2);
    check("R3", "restarted window no fault", ov_fault, 1'b0);
    check("R3", "restarted window no lowside", lowside_on, 1'b0);
    check("R3", "restarted window pgood kept", pgood, 1'b1);
  endtask

  task automatic t_hot();
    hot_flag = 1'b1;
    cyc(1);
    check("R8", "suspend one clock after hot", pwm_suspend, 1'b1);
    cyc(3 * DG);
    check("R8", "hot leaves pgood", pgood, 1'b1);
    check("R8", "hot latches nothing", ov_fault | uv_fault, 1'b0);
    hot_flag = 1'b0;
    cyc(1);
    check("R8", "suspend released", pwm_suspend, 1'b0);
  endtask

  task automatic t_at90();
    at90_flag = 1'b0;
    cyc(DG - 1);
    check("R2", "pgood kept inside window", pgood, 1'b1);
    cyc(1);
    check("R2", "pgood drops below 90", pgood, 1'b0);
    at90_flag = 1'b1;
    cyc(DG);
    check("R2", "pgood returns at 90", pgood, 1'b1);
  endtask

  task automatic t_over();
    over_flag = 1'b1;
    cyc(DG - 1);
    check("R1", "pgood before window", pgood, 1'b1);
    cyc(1);
    check("R1", "pgood drops over range", pgood, 1'b0);
    check("R4", "fault one clock after window", ov_fault, 1'b0);
    cyc(1);
    check("R4", "ov fault latched", ov_fault, 1'b1);
    check("R4", "lowside on", lowside_on, 1'b1);
    check("R4", "no hiz on ov", hiz_out, 1'b0);
    check("R8", "suspend on fault", pwm_suspend, 1'b1);
    over_flag = 1'b0;
    cyc(3 * DG);
    check("R4", "ov fault held", ov_fault, 1'b1);
    check("R9", "pgood low with fault", pgood, 1'b0);
    under_flag = 1'b1;
    cyc(2 * DG);
    check("R6", "no second fault", uv_fault, 1'b0);
    under_flag = 1'b0;
    supply_ok = 1'b0;
    cyc(1);
    check("R7", "supply drop clears ov", ov_fault | lowside_on, 1'b0);
    check("R7", "pgood low while stopped", pgood, 1'b0);
    supply_ok = 1'b1;
    cyc(DG);
    check("R7", "pgood back after clear", pgood, 1'b1);
  endtask

  task automatic t_under();
    under_flag = 1'b1;
    cyc(DG);
    check("R1", "pgood drops under range", pgood, 1'b0);
    check("R5", "uv not yet latched", uv_fault, 1'b0);
    cyc(1);
    check("R5", "uv fault latched", uv_fault, 1'b1);
    check("R5", "hiz on", hiz_out, 1'b1);
    check("R5", "lowside off on uv", lowside_on, 1'b0);
    under_flag = 1'b0;
    cyc(2 * DG);
    check("R5", "uv fault held", uv_fault, 1'b1);
    check("R9", "pgood low with uv", pgood, 1'b0);
    enable = 1'b0;
    cyc(2);
    check("R7", "enable drop clears uv", uv_fault | hiz_out, 1'b0);
    enable = 1'b1;
    cyc(DG);
    check("R7", "pgood back after enable", pgood, 1'b1);
  endtask

  task automatic t_uv_mask();
    soft_done = 1'b0;
    under_flag = 1'b1;
    cyc(3 * DG);
    check("R5", "uv masked before soft done", uv_fault, 1'b0);
    check("R5", "no hiz while masked", hiz_out, 1'b0);
    under_flag = 1'b0;
    soft_done = 1'b1;
    cyc(DG);
    check("R2", "pgood after soft done again", pgood, 1'b1);
  endtask

  task automatic t_tie();
    over_flag = 1'b1;
    under_flag = 1'b1;
    cyc(DG + 1);
    check("R6", "tie latches ov", ov_fault, 1'b1);
    check("R6", "tie leaves uv clear", uv_fault, 1'b0);
    over_flag = 1'b0;
    under_flag = 1'b0;
    restart();
  endtask

  initial begin
    t_reset();
    t_startup();
    t_glitch();
    t_hot();
    t_at90();
    t_over();
    t_under();
    t_uv_mask();
    t_tie();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule